// File: doc/BRIEF.md
# Start-of-Line Sync Framer

This block sits after the lane deserializer of an image-sensor receiver. It takes one sample word per valid cycle and rebuilds the frame and line timing from the stream. The sensor marks the start of each line with a five-word code. The sensor sends no code at the end of a line. The last word of the start code tells whether the line opens a new frame. The block therefore searches the stream for the start code, then counts pixel words up to a programmed line length. It drops everything outside that active window.

Active pixel words are packed into beats of several words and leave on an AXI4-Stream master interface without backpressure. `m_tuser` marks the first beat of a frame, and `m_tlast` marks the beat that holds the last pixel of a line. A line index travels with every beat. It restarts at zero on the line that opens a frame.

Top module: `sol_framer`

## Requirements
- R1: After reset, `m_tvalid`, `m_tuser`, `m_tlast`, `m_tdata` and `m_line` are zero, and the block searches for a start code.
- R2: A start code is five valid words: all-ones, all-zeros, all-ones, all-zeros, then a fifth word. A fifth word of all-ones marks a frame-start line. A fifth word of all-zeros marks an ordinary line.
- R3: A word that breaks the code sends the search back to the beginning. If the breaking word is all-ones, it counts as the first word of a new code. For example, ones,ones,zeros,ones,zeros,ones is a frame start, and ones,zeros,zeros,ones,zeros,ones,zeros,zeros is an ordinary line start.
- R4: Words outside an active line produce no beat. This covers blanking, incomplete or broken codes, and cycles with `s_valid` low at any time. Cycles with `s_valid` low also do not advance the pixel count.
- R5: Pixel k of a line (counting from 0) goes to lane k mod PACK of its beat. Lane i occupies bits [i*WORD_W +: WORD_W]. A beat is emitted one cycle after the valid cycle that carries the word filling its last lane.
- R6: The beat that carries pixel `line_len`-1 is emitted at once, with `m_tlast` high. Lanes above that pixel in a partial beat are zero. A `line_len` of 0 acts as 1.
- R7: `m_tuser` is high only on the first beat of a frame-start line. It is low on every other beat, including the first beat of an ordinary line.
- R8: `m_line` is 0 on the beats of a frame-start line. Each ordinary line carries the previous line's index plus one, modulo 2^LINE_W.
- R9: Inside an active line, words equal to all-ones or all-zeros are pixel data and do not restart the search.
- R10: After the last pixel of a line, no beat is produced until a full new start code has been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample word qualifier |
| s_word | input | WORD_W | Sample word from the deserializer |
| line_len | input | LEN_W | Active pixels per line |
| m_tvalid | output | 1 | Beat valid |
| m_tdata | output | PACK*WORD_W | Packed pixel words, lane 0 in the low bits |
| m_tuser | output | 1 | First beat of a frame |
| m_tlast | output | 1 | Beat holding the last pixel of a line |
| m_line | output | LINE_W | Line index within the frame |

## Verification
Frame start and line end can land on the same beat. This happens when `line_len` is no larger than PACK: a single partial beat then carries both `m_tuser` and `m_tlast`. The bench sweeps `line_len` from 1 to 9 with PACK=4, so single-beat, partial and multi-beat lines all occur after both kinds of start code. It predicts every output cycle from the word index. Each beat is judged on all fields at once: data with its zeroed upper lanes, both markers, and the line index.

// File: rtl/sol_pkg.sv
package sol_pkg;
   typedef enum logic [2:0] {
      ST_HUNT = 3'd0,
      ST_W1   = 3'd1,
      ST_W2   = 3'd2,
      ST_W3   = 3'd3,
      ST_W4   = 3'd4
   } sync_st_t;
endpackage

// File: rtl/solf_sync_hunt.sv
module solf_sync_hunt
   import sol_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [WORD_W-1:0] word,
   output logic              sol_stb,
   output logic              sol_first,
   output sync_st_t          state_o
);
   sync_st_t st_q, st_d;
   logic     is_ones, is_zero;

   assign is_ones = (word == {WORD_W{1'b1}});
   assign is_zero = (word == {WORD_W{1'b0}});
   assign state_o = st_q;

   always_comb begin
      st_d      = st_q;
      sol_stb   = 1'b0;
      sol_first = 1'b0;
      if (en) begin
         unique case (st_q)
            ST_HUNT: st_d = is_ones ? ST_W1 : ST_HUNT;
            ST_W1:   st_d = is_zero ? ST_W2 : (is_ones ? ST_W1 : ST_HUNT);
            ST_W2:   st_d = is_ones ? ST_W3 : ST_HUNT;
            ST_W3:   st_d = is_zero ? ST_W4 : (is_ones ? ST_W1 : ST_HUNT);
            ST_W4: begin
               st_d      = ST_HUNT;
               sol_stb   = is_ones | is_zero;
               sol_first = is_ones;
            end
            default: st_d = ST_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_HUNT;
      else        st_q <= st_d;
   end

   // R2: a detected start returns the search to its beginning
   p_start_rearms_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sol_stb |=> (st_q == ST_HUNT));
   // R3: the search never advances on a word that is neither code value
   p_stray_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !is_ones && !is_zero) |=> (st_q == ST_HUNT));
endmodule

// File: rtl/solf_line_ctrl.sv
module solf_line_ctrl #(
   parameter int PACK   = 4,
   parameter int LEN_W  = 14,
   parameter int LINE_W = 13,
   localparam int LANE_W = (PACK > 1) ? $clog2(PACK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [LEN_W-1:0]  line_len,
   input  logic              sol_stb,
   input  logic              sol_first,
   output logic              active_o,
   output logic              wr_o,
   output logic [LANE_W-1:0] lane_o,
   output logic              close_o,
   output logic              user_o,
   output logic              last_o,
   output logic [LINE_W-1:0] line_o
);
   logic              active_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LANE_W-1:0] lane_q;
   logic              first_beat_q;
   logic              frame_line_q;
   logic [LINE_W-1:0] line_q;
   logic              last_word, lane_full;

   assign wr_o      = active_q & s_valid;
   assign last_word = ({1'b0, cnt_q} + (LEN_W+1)'(1)) >= {1'b0, line_len};
   assign lane_full = (lane_q == LANE_W'(PACK-1));
   assign close_o   = wr_o & (lane_full | last_word);
   assign user_o    = first_beat_q & frame_line_q;
   assign last_o    = last_word;
   assign lane_o    = lane_q;
   assign active_o  = active_q;
   assign line_o    = line_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q     <= 1'b0;
         cnt_q        <= '0;
         lane_q       <= '0;
         first_beat_q <= 1'b0;
         frame_line_q <= 1'b0;
         line_q       <= '0;
      end else if (!active_q) begin
         if (sol_stb) begin
            active_q     <= 1'b1;
            cnt_q        <= '0;
            lane_q       <= '0;
            first_beat_q <= 1'b1;
            frame_line_q <= sol_first;
            line_q       <= sol_first ? '0 : line_q + LINE_W'(1);
         end
      end else if (wr_o) begin
         cnt_q  <= cnt_q + LEN_W'(1);
         lane_q <= close_o ? '0 : lane_q + LANE_W'(1);
         if (close_o)   first_beat_q <= 1'b0;
         if (last_word) active_q     <= 1'b0;
      end
   end

   // R6: the pixel count stays inside the programmed line
   p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && line_len != '0) |-> (cnt_q < line_len));
   // R5: lane pointer stays within the beat
   p_lane_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_q <= LANE_W'(PACK-1));
endmodule

// File: rtl/solf_beat_pack.sv
module solf_beat_pack #(
   parameter int WORD_W = 12,
   parameter int PACK   = 4,
   parameter int LINE_W = 13,
   localparam int LANE_W = (PACK > 1) ? $clog2(PACK) : 1,
   localparam int DATA_W = WORD_W * PACK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [LANE_W-1:0] lane,
   input  logic [WORD_W-1:0] word,
   input  logic              close,
   input  logic              user,
   input  logic              last,
   input  logic [LINE_W-1:0] line,
   output logic              m_tvalid,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tuser,
   output logic              m_tlast,
   output logic [LINE_W-1:0] m_line
);
   logic [DATA_W-1:0] beat_d;

   generate
      if (PACK == 1) begin : g_direct
         assign beat_d = word;
      end else begin : g_lanes
         for (genvar g = 0; g < PACK; g++) begin : g_lane
            logic [WORD_W-1:0] hold_q;
            always_ff @(posedge clk) begin
               if (!rst_n)                            hold_q <= '0;
               else if (wr && lane == LANE_W'(g))     hold_q <= word;
            end
            assign beat_d[g*WORD_W +: WORD_W] =
               (lane == LANE_W'(g)) ? word :
               ((LANE_W'(g) < lane) ? hold_q : '0);
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_tvalid <= 1'b0;
         m_tdata  <= '0;
         m_tuser  <= 1'b0;
         m_tlast  <= 1'b0;
         m_line   <= '0;
      end else begin
         m_tvalid <= close;
         m_tuser  <= close & user;
         m_tlast  <= close & last;
         if (close) begin
            m_tdata <= beat_d;
            m_line  <= line;
         end
      end
   end

   // R6: line end marker only on a real beat
   p_last_on_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid);
   // R7: frame marker only on a real beat
   p_user_on_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      m_tuser |-> m_tvalid);
endmodule

// File: rtl/sol_framer.sv
module sol_framer
   import sol_pkg::*;
#(
   parameter int WORD_W = 12,
   parameter int PACK   = 4,
   parameter int LEN_W  = 14,
   parameter int LINE_W = 13,
   localparam int LANE_W = (PACK > 1) ? $clog2(PACK) : 1,
   localparam int DATA_W = WORD_W * PACK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_valid,
   input  logic [WORD_W-1:0] s_word,
   input  logic [LEN_W-1:0]  line_len,
   output logic              m_tvalid,
   output logic [DATA_W-1:0] m_tdata,
   output logic              m_tuser,
   output logic              m_tlast,
   output logic [LINE_W-1:0] m_line
);
   generate
      if (WORD_W < 2)  begin : g_bad_word $error("WORD_W must be at least 2"); end
      if (PACK < 1)    begin : g_bad_pack $error("PACK must be at least 1"); end
      if (LEN_W < 1)   begin : g_bad_len  $error("LEN_W must be at least 1"); end
      if (LINE_W < 1)  begin : g_bad_line $error("LINE_W must be at least 1"); end
   endgenerate

   logic              sol_stb, sol_first, active, wr, close, user, last;
   logic [LANE_W-1:0] lane;
   logic [LINE_W-1:0] line_idx;
   sync_st_t          det_state;

   solf_sync_hunt #(.WORD_W(WORD_W)) hunt_i (
      .clk(clk), .rst_n(rst_n), .en(s_valid & ~active), .word(s_word),
      .sol_stb(sol_stb), .sol_first(sol_first), .state_o(det_state));

   solf_line_ctrl #(.PACK(PACK), .LEN_W(LEN_W), .LINE_W(LINE_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .line_len(line_len),
      .sol_stb(sol_stb), .sol_first(sol_first), .active_o(active),
      .wr_o(wr), .lane_o(lane), .close_o(close), .user_o(user),
      .last_o(last), .line_o(line_idx));

   solf_beat_pack #(.WORD_W(WORD_W), .PACK(PACK), .LINE_W(LINE_W)) pack_i (
      .clk(clk), .rst_n(rst_n), .wr(wr), .lane(lane), .word(s_word),
      .close(close), .user(user), .last(last), .line(line_idx),
      .m_tvalid(m_tvalid), .m_tdata(m_tdata), .m_tuser(m_tuser),
      .m_tlast(m_tlast), .m_line(m_line));

   // R9: the code search is parked while a line is active
   p_hunt_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (det_state == ST_HUNT));
   // R4: every beat comes from a word taken inside an active line
   p_beat_from_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
      m_tvalid |-> $past(active));
   // R10: a line-end beat leaves the block outside the active window
   p_end_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> !active);
endmodule

// File: tb/sol_framer_tb_top.sv
`timescale 1ns/1ps
module sol_framer_tb_top;
   localparam int W = 12;
   localparam int P = 4;
   localparam int LW = 14;
   localparam int NW = 13;
   localparam logic [W-1:0] ONES = '1;
   localparam logic [W-1:0] ZERO = '0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic [W-1:0]  s_word = '0;
   logic [LW-1:0] line_len = LW'(4);
   logic          m_tvalid, m_tuser, m_tlast;
   logic [W*P-1:0] m_tdata;
   logic [NW-1:0] m_line;

   int checks = 0;
   int failures = 0;
   logic [NW-1:0] exp_line = '0;
   bit done = 0;

   always #2.5 clk = ~clk;

   sol_framer dut_i (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_word(s_word),
      .line_len(line_len), .m_tvalid(m_tvalid), .m_tdata(m_tdata),
      .m_tuser(m_tuser), .m_tlast(m_tlast), .m_line(m_line));

   // Drive one cycle, then judge the outputs just after the sampling edge.
   task automatic put(input logic v, input logic [W-1:0] d, input logic ev,
                      input logic [W*P-1:0] ed, input logic eu, input logic el,
                      input logic [NW-1:0] eln, input string tag);
      logic ok;
      @(negedge clk);
      s_valid = v;
      s_word  = d;
      @(posedge clk);
      #1;
      checks++;
      if (!ev) ok = (m_tvalid == 1'b0);
      else ok = m_tvalid && (m_tdata == ed) && (m_tuser == eu) &&
                (m_tlast == el) && (m_line == eln);
      if (!ok) begin
         failures++;
         $display("FAIL %s: got v=%0b d=%h u=%0b l=%0b line=%0d exp v=%0b d=%h u=%0b l=%0b line=%0d",
                  tag, m_tvalid, m_tdata, m_tuser, m_tlast, m_line,
                  ev, ed, eu, el, eln);
      end
   endtask

   task automatic quiet(input logic v, input logic [W-1:0] d, input string tag);
      put(v, d, 1'b0, '0, 1'b0, 1'b0, '0, tag);
   endtask

   // R2: the four fixed words then the kind word
   task automatic send_sync(input bit first);
      quiet(1'b1, ONES, "R2 R4");
      quiet(1'b1, ZERO, "R2 R4");
      quiet(1'b1, ONES, "R2 R4");
      quiet(1'b1, ZERO, "R2 R4");
      quiet(1'b1, first ? ONES : ZERO, "R2 R4");
      exp_line = first ? '0 : exp_line + NW'(1);
   endtask

   // mode 0: arithmetic pixels; mode 1: alternating code values (R9)
   task automatic send_line(input int len, input bit first, input int mode,
                            input bit gaps, input int base);
      logic [W*P-1:0] acc;
      logic [W-1:0] pix;
      int eff;
      bit firstbeat;
      eff = (len == 0) ? 1 : len;
      acc = '0;
      firstbeat = 1;
      for (int k = 0; k < eff; k++) begin
         int lane;
         bit emit, lst;
         lane = k % P;
         if (mode == 1) pix = (k % 2 == 0) ? ONES : ZERO;
         else           pix = W'((base + 7 * k + 1) & 12'hFFF);
         if (lane == 0) acc = '0;
         acc[lane*W +: W] = pix;
         lst  = (k == eff - 1);
         emit = (lane == P - 1) || lst;
         if (emit) begin
            put(1'b1, pix, 1'b1, acc, first && firstbeat, lst, exp_line,
                lst ? "R6 R5 R7 R8" : "R5 R7 R8");
            firstbeat = 0;
         end else begin
            put(1'b1, pix, 1'b0, '0, 1'b0, 1'b0, '0, "R5");
         end
         if (gaps && !lst) quiet(1'b0, ONES, "R4 gap");
      end
   endtask

   task automatic blank(input int n);
      for (int i = 0; i < n; i++) quiet(1'b1, 12'h3C3, "R4 R10 blanking");
      quiet(1'b0, ONES, "R4 idle");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got hung exp finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      checks++;
      if (m_tvalid || m_tuser || m_tlast || m_tdata != '0 || m_line != '0) begin
         failures++;
         $display("FAIL R1: got v=%0b d=%h line=%0d exp all zero", m_tvalid, m_tdata, m_line);
      end
      @(negedge clk);
      rst_n = 1'b1;
      // R1: a lone ordinary kind word after reset must not start a line
      quiet(1'b1, ZERO, "R1");
      quiet(1'b1, 12'h111, "R1");

      // Sweep line lengths: single, partial and multi-beat lines
      for (int len = 1; len <= 9; len++) begin
         @(negedge clk);
         line_len = LW'(len);
         send_sync(1);  send_line(len, 1, 0, 0, len * 16);      blank(3);
         send_sync(0);  send_line(len, 0, 0, 0, len * 16 + 5);  blank(2);
         send_sync(0);  send_line(len, 0, 0, len % 2, len * 16 + 9);
         // R10: words after the line end without a new code are dropped
         quiet(1'b1, 12'h222, "R10");
         quiet(1'b1, 12'h333, "R10");
      end

      // R3: repeated ones restarts, then a frame start
      @(negedge clk);
      line_len = LW'(5);
      quiet(1'b1, ONES, "R3");
      send_sync(1);
      send_line(5, 1, 0, 0, 100);
      blank(2);
      // R3: ones in the fourth position restarts the code
      quiet(1'b1, ONES, "R3"); quiet(1'b1, ZERO, "R3"); quiet(1'b1, ONES, "R3");
      send_sync(0);
      send_line(5, 0, 0, 0, 200);
      blank(2);
      // R3: zeros in the third position returns to the search start
      quiet(1'b1, ONES, "R3"); quiet(1'b1, ZERO, "R3"); quiet(1'b1, ZERO, "R3");
      send_sync(0);
      send_line(5, 0, 0, 0, 300);
      blank(1);
      // R3: stray fifth word aborts; following words give no beats
      quiet(1'b1, ONES, "R3"); quiet(1'b1, ZERO, "R3"); quiet(1'b1, ONES, "R3");
      quiet(1'b1, ZERO, "R3"); quiet(1'b1, 12'h5A5, "R3");
      for (int i = 0; i < 8; i++) quiet(1'b1, W'(12'h10 + i), "R3");
      // R3: stray word in the middle aborts too
      quiet(1'b1, ONES, "R3"); quiet(1'b1, 12'h001, "R3"); quiet(1'b1, ONES, "R3");
      quiet(1'b1, ZERO, "R3"); quiet(1'b1, ONES, "R3");
      for (int i = 0; i < 6; i++) quiet(1'b1, W'(12'h40 + i), "R3");

      // R9: code-valued pixels inside the line are data
      @(negedge clk);
      line_len = LW'(7);
      send_sync(0);
      send_line(7, 0, 1, 0, 0);
      send_sync(0);
      send_line(7, 0, 1, 1, 0);

      // R6: a line length of zero behaves as one pixel
      @(negedge clk);
      line_len = '0;
      send_sync(1);
      send_line(0, 1, 0, 0, 55);
      blank(2);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule